// File: doc/BRIEF.md
# Line-Buffered Video Timebase Handoff

This block moves a pixel stream, together with its line and frame timing, from a camera clock domain into a display clock domain. A dual-clock FIFO a few lines deep takes the place of a frame store. The display timing generator is not free-running. It is held in reset by this block and released only once the camera has delivered enough lines of the current frame, so the display follows the camera's frame cadence and no frame buffer is needed.

Each side keeps its own view of whether a frame is in progress. The camera side uses frame-start and frame-end pulses. The display side sees the camera's frame status through a synchronizer. The FIFO pointers on both sides are cleared whenever either view says the frame is over, so every frame starts from an empty buffer.

Read-out is tied to the display's own line structure. Pixels are popped only while the display reports active video, and only after a display line start has been seen since its reset was released. Overflow and underflow are recorded in sticky flags.

Top module: `vid_line_handoff`

## Requirements
- R1: Every pixel written while the FIFO is out of reset leaves on `dsp_pix` unchanged and in arrival order. `dsp_pix_vld` is high for one display cycle per pixel, one cycle after the read.
- R2: The camera is in frame from a cycle with `cam_fs` high until a cycle with `cam_fe` high. `cam_fe` wins if both are high in the same cycle. Pixels offered with `cam_vld` while the camera is out of frame are discarded and never appear on `dsp_pix`.
- R3: `cam_fifo_rst` and `dsp_fifo_rst` are 1 whenever the camera side or the display side is out of frame, and are 0 during the lines of a frame.
- R4: `dsp_tg_rst` is 1 out of frame. It stays 1 through the first START_LINES camera lines of a frame, and drops only after line start number START_LINES+1 (default 2). It returns to 1 after `cam_fe`.
- R5: A read happens only in a cycle with `dsp_de` high, after a `dsp_ls` pulse has been seen since `dsp_tg_rst` last fell. With no display line starts, nothing is read out.
- R6: A write offered while the FIFO is full is dropped and sets `cam_ovf`. `cam_ovf` stays 1 until `cam_rst`.
- R7: A read attempted while the FIFO is empty produces no `dsp_pix_vld` and sets `dsp_udf`. `dsp_udf` stays 1 until `dsp_rst`.
- R8: While reset, `dsp_tg_rst`, `cam_fifo_rst` and `dsp_fifo_rst` are 1, and `dsp_pix_vld`, `cam_ovf` and `dsp_udf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cam_clk | input | 1 | Camera domain clock |
| cam_rst | input | 1 | Camera domain synchronous reset, active high |
| cam_pix | input | PIX_W | Camera pixel |
| cam_vld | input | 1 | Camera pixel valid |
| cam_fs | input | 1 | Camera frame start pulse |
| cam_fe | input | 1 | Camera frame end pulse |
| cam_ls | input | 1 | Camera line start pulse |
| dsp_clk | input | 1 | Display domain clock |
| dsp_rst | input | 1 | Display domain synchronous reset, active high |
| dsp_ls | input | 1 | Display line start pulse from the timing generator |
| dsp_de | input | 1 | Display active video |
| dsp_pix | output | PIX_W | Pixel read out in the display domain |
| dsp_pix_vld | output | 1 | `dsp_pix` holds a fresh pixel |
| cam_fifo_rst | output | 1 | FIFO clear, camera side |
| dsp_fifo_rst | output | 1 | FIFO clear, display side |
| dsp_tg_rst | output | 1 | Reset for the display timing generator |
| cam_ovf | output | 1 | Sticky overflow flag (camera domain) |
| dsp_udf | output | 1 | Sticky underflow flag (display domain) |

## Verification
The hardest state to reach is the one where the display side keeps running but the data is gone. That means display line starts arrive after the camera's last line has been drained, yet before the frame end has cleared the FIFO. The bench's display generator is released by `dsp_tg_rst` and can be told to produce more lines than the camera sends. It holds a long vertical blanking before `cam_fe`, so the extra lines meet an empty FIFO. Overflow is reached by turning the display generator off for a frame, so no line start ever opens reading and the camera's lines fill the buffer.

// File: rtl/vlh_pkg.sv
package vlh_pkg;
  localparam int unsigned VLH_PIX_W_DEF    = 24;
  localparam int unsigned VLH_LINE_PIX_DEF = 16;
  localparam int unsigned VLH_DEPTH_DEF    = 64;
  localparam int unsigned VLH_START_DEF    = 1;

  // display read-out gate
  typedef enum logic [1:0] {
    RD_HOLD  = 2'd0,  // timing generator in reset
    RD_ARMED = 2'd1,  // released, waiting for a line start
    RD_OPEN  = 2'd2   // reads follow active video
  } rd_state_t;
endpackage

// File: rtl/vlh_sync.sv
module vlh_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/vlh_cam_ctrl.sv
module vlh_cam_ctrl #(
  parameter int unsigned START_LINES = 1
) (
  input  logic cam_clk,
  input  logic cam_rst,
  input  logic cam_fs,
  input  logic cam_fe,
  input  logic cam_ls,
  input  logic dsp_frame_s,   // display in-frame, synchronized
  output logic inframe,
  output logic go,
  output logic fifo_rst
);
  localparam int unsigned LIM = START_LINES + 1;
  localparam int unsigned CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIM);

  logic [CW-1:0] line_cnt;

  always_ff @(posedge cam_clk) begin
    if (cam_rst) begin
      inframe  <= 1'b0;
      line_cnt <= '0;
      go       <= 1'b0;
      fifo_rst <= 1'b1;
    end else begin
      if (cam_fe)      inframe <= 1'b0;
      else if (cam_fs) inframe <= 1'b1;

      if (!inframe || cam_fe)
        line_cnt <= '0;
      else if (cam_ls && line_cnt != LIM_C)
        line_cnt <= line_cnt + 1'b1;

      go       <= inframe && !cam_fe && (line_cnt == LIM_C);
      fifo_rst <= !inframe || !dsp_frame_s;
    end
  end
endmodule

// File: rtl/vlh_dsp_ctrl.sv
module vlh_dsp_ctrl
  import vlh_pkg::*;
(
  input  logic dsp_clk,
  input  logic dsp_rst,
  input  logic cam_frame_s,   // camera in-frame, synchronized
  input  logic cam_go_s,      // camera start threshold reached, synchronized
  input  logic dsp_ls,
  input  logic dsp_de,
  output logic inframe,
  output logic tg_rst,
  output logic fifo_rst,
  output logic rd_req
);
  logic      frame_d;
  logic      fs_p;
  logic      fe_p;
  rd_state_t st;

  assign fs_p = cam_frame_s && !frame_d;
  assign fe_p = !cam_frame_s && frame_d;

  always_ff @(posedge dsp_clk) begin
    if (dsp_rst) begin
      frame_d  <= 1'b0;
      inframe  <= 1'b0;
      tg_rst   <= 1'b1;
      fifo_rst <= 1'b1;
      st       <= RD_HOLD;
    end else begin
      frame_d <= cam_frame_s;
      if (fe_p)      inframe <= 1'b0;
      else if (fs_p) inframe <= 1'b1;

      tg_rst   <= !(inframe && cam_go_s);
      fifo_rst <= !inframe || !cam_frame_s;

      if (tg_rst) st <= RD_HOLD;
      else begin
        case (st)
          RD_HOLD:  st <= dsp_ls ? RD_OPEN : RD_ARMED;
          RD_ARMED: if (dsp_ls) st <= RD_OPEN;
          default:  st <= RD_OPEN;
        endcase
      end
    end
  end

  assign rd_req = (st == RD_OPEN) && dsp_de;
endmodule

// File: rtl/vlh_afifo.sv
module vlh_afifo #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned DEPTH = 64
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             wclr,
  input  logic             wen,
  input  logic [PIX_W-1:0] wdata,
  output logic             ovf,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             rclr,
  input  logic             ren,
  output logic [PIX_W-1:0] rdata,
  output logic             rvld,
  output logic             udf
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] FULL_X = {2'b11, {(PW-2){1'b0}}};
  localparam logic [PW-1:0] ONE    = {{(PW-1){1'b0}}, 1'b1};

  logic [PIX_W-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, wbin_n, wq_gray;
  logic [PW-1:0] rbin, rgray, rbin_n, rq_gray;
  logic          full, empty, wfire, rfire;

  // write side
  assign wbin_n = wbin + ONE;
  assign full   = ((wgray ^ rq_gray) == FULL_X);
  assign wfire  = wen && !wclr && !full;

  always_ff @(posedge wclk) begin
    if (wrst || wclr) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wfire) begin
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
    end
  end

  always_ff @(posedge wclk) begin
    if (wrst)                      ovf <= 1'b0;
    else if (wen && !wclr && full) ovf <= 1'b1;
  end

  always_ff @(posedge wclk) begin
    if (wfire) mem[wbin[AW-1:0]] <= wdata;
  end

  // read side
  assign rbin_n = rbin + ONE;
  assign empty  = (rgray == wq_gray);
  assign rfire  = ren && !rclr && !empty;

  always_ff @(posedge rclk) begin
    if (rrst || rclr) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rfire) begin
      rbin  <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
    end
  end

  always_ff @(posedge rclk) begin
    if (rfire) rdata <= mem[rbin[AW-1:0]];
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rvld <= 1'b0;
      udf  <= 1'b0;
    end else begin
      rvld <= rfire;
      if (ren && !rclr && empty) udf <= 1'b1;
    end
  end

  // pointer crossings: Gray codes only, levels never cross
  vlh_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wq_gray));
  vlh_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(rq_gray));
endmodule

// File: rtl/vid_line_handoff.sv
module vid_line_handoff
  import vlh_pkg::*;
#(
  parameter int unsigned PIX_W       = VLH_PIX_W_DEF,
  parameter int unsigned LINE_PIX    = VLH_LINE_PIX_DEF,
  parameter int unsigned DEPTH       = VLH_DEPTH_DEF,
  parameter int unsigned START_LINES = VLH_START_DEF
) (
  input  logic             cam_clk,
  input  logic             cam_rst,
  input  logic [PIX_W-1:0] cam_pix,
  input  logic             cam_vld,
  input  logic             cam_fs,
  input  logic             cam_fe,
  input  logic             cam_ls,
  input  logic             dsp_clk,
  input  logic             dsp_rst,
  input  logic             dsp_ls,
  input  logic             dsp_de,
  output logic [PIX_W-1:0] dsp_pix,
  output logic             dsp_pix_vld,
  output logic             cam_fifo_rst,
  output logic             dsp_fifo_rst,
  output logic             dsp_tg_rst,
  output logic             cam_ovf,
  output logic             dsp_udf
);
  if (DEPTH < LINE_PIX || DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
    $error("DEPTH must be a power of two, at least 4 and at least LINE_PIX");
  end

  logic cam_inframe, cam_go;
  logic dsp_inframe, dsp_rd_req;
  logic cam_frame_s, cam_go_s, dsp_frame_s;

  vlh_cam_ctrl #(.START_LINES(START_LINES)) u_cam (
    .cam_clk     (cam_clk),
    .cam_rst     (cam_rst),
    .cam_fs      (cam_fs),
    .cam_fe      (cam_fe),
    .cam_ls      (cam_ls),
    .dsp_frame_s (dsp_frame_s),
    .inframe     (cam_inframe),
    .go          (cam_go),
    .fifo_rst    (cam_fifo_rst)
  );

  vlh_sync #(.W(2)) u_c2d (
    .clk (dsp_clk),
    .rst (dsp_rst),
    .d   ({cam_inframe, cam_go}),
    .q   ({cam_frame_s, cam_go_s})
  );

  vlh_sync #(.W(1)) u_d2c (
    .clk (cam_clk),
    .rst (cam_rst),
    .d   (dsp_inframe),
    .q   (dsp_frame_s)
  );

  vlh_dsp_ctrl u_dsp (
    .dsp_clk     (dsp_clk),
    .dsp_rst     (dsp_rst),
    .cam_frame_s (cam_frame_s),
    .cam_go_s    (cam_go_s),
    .dsp_ls      (dsp_ls),
    .dsp_de      (dsp_de),
    .inframe     (dsp_inframe),
    .tg_rst      (dsp_tg_rst),
    .fifo_rst    (dsp_fifo_rst),
    .rd_req      (dsp_rd_req)
  );

  vlh_afifo #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_fifo (
    .wclk  (cam_clk),
    .wrst  (cam_rst),
    .wclr  (cam_fifo_rst),
    .wen   (cam_vld),
    .wdata (cam_pix),
    .ovf   (cam_ovf),
    .rclk  (dsp_clk),
    .rrst  (dsp_rst),
    .rclr  (dsp_fifo_rst),
    .ren   (dsp_rd_req),
    .rdata (dsp_pix),
    .rvld  (dsp_pix_vld),
    .udf   (dsp_udf)
  );
endmodule

// File: rtl/vlh_checker.sv
module vlh_checker (
  input logic cam_clk,
  input logic cam_rst,
  input logic dsp_clk,
  input logic dsp_rst,
  input logic cam_inframe,
  input logic dsp_inframe,
  input logic cam_fifo_rst,
  input logic dsp_fifo_rst,
  input logic dsp_tg_rst,
  input logic dsp_de,
  input logic dsp_pix_vld,
  input logic cam_ovf,
  input logic dsp_udf
);
  assert_cam_clear_out_of_frame_R3: assert property (@(posedge cam_clk) disable iff (cam_rst)
    !cam_inframe |=> cam_fifo_rst);

  assert_dsp_clear_out_of_frame_R3: assert property (@(posedge dsp_clk) disable iff (dsp_rst)
    !dsp_inframe |=> dsp_fifo_rst);

  assert_tg_held_out_of_frame_R4: assert property (@(posedge dsp_clk) disable iff (dsp_rst)
    !dsp_inframe |=> dsp_tg_rst);

  assert_read_needs_active_R5: assert property (@(posedge dsp_clk) disable iff (dsp_rst)
    dsp_pix_vld |-> $past(dsp_de));

  assert_read_outside_clear_R1: assert property (@(posedge dsp_clk) disable iff (dsp_rst)
    dsp_pix_vld |-> $past(!dsp_fifo_rst));

  assert_ovf_sticky_R6: assert property (@(posedge cam_clk) disable iff (cam_rst)
    cam_ovf |=> cam_ovf);

  assert_udf_sticky_R7: assert property (@(posedge dsp_clk) disable iff (dsp_rst)
    dsp_udf |=> dsp_udf);
endmodule

bind vid_line_handoff vlh_checker u_vlh_checker (
  .cam_clk      (cam_clk),
  .cam_rst      (cam_rst),
  .dsp_clk      (dsp_clk),
  .dsp_rst      (dsp_rst),
  .cam_inframe  (cam_inframe),
  .dsp_inframe  (dsp_inframe),
  .cam_fifo_rst (cam_fifo_rst),
  .dsp_fifo_rst (dsp_fifo_rst),
  .dsp_tg_rst   (dsp_tg_rst),
  .dsp_de       (dsp_de),
  .dsp_pix_vld  (dsp_pix_vld),
  .cam_ovf      (cam_ovf),
  .dsp_udf      (dsp_udf)
);

// File: tb/test_vid_line_handoff.sv
`timescale 1ns/1ps
module test_vid_line_handoff;
  localparam int PIX_W    = 24;
  localparam int LINE_PIX = 16;
  localparam int DEPTH    = 64;
  localparam int LINES    = 6;
  localparam int RXN      = 1024;

  typedef struct packed {
    logic [23:0] base;
    logic [7:0]  step;
    logic        pre;   // offer junk pixels before the frame starts
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{24'h000100, 8'd1,  1'b0},
    '{24'hA5A500, 8'd7,  1'b1},
    '{24'hFFFFF0, 8'd3,  1'b0},
    '{24'h123456, 8'd255, 1'b1}
  };

  logic             cam_clk = 0, dsp_clk = 0;
  logic             cam_rst = 1, dsp_rst = 1;
  logic [PIX_W-1:0] cam_pix = '0;
  logic             cam_vld = 0, cam_fs = 0, cam_fe = 0, cam_ls = 0;
  logic             dsp_ls = 0, dsp_de = 0;
  logic [PIX_W-1:0] dsp_pix;
  logic             dsp_pix_vld, cam_fifo_rst, dsp_fifo_rst, dsp_tg_rst, cam_ovf, dsp_udf;

  always #4 dsp_clk = ~dsp_clk;   // 125 MHz
  always #5 cam_clk = ~cam_clk;

  vid_line_handoff #(.PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .DEPTH(DEPTH), .START_LINES(1)) i_vid_line_handoff (
    .cam_clk(cam_clk), .cam_rst(cam_rst), .cam_pix(cam_pix), .cam_vld(cam_vld),
    .cam_fs(cam_fs), .cam_fe(cam_fe), .cam_ls(cam_ls),
    .dsp_clk(dsp_clk), .dsp_rst(dsp_rst), .dsp_ls(dsp_ls), .dsp_de(dsp_de),
    .dsp_pix(dsp_pix), .dsp_pix_vld(dsp_pix_vld), .cam_fifo_rst(cam_fifo_rst),
    .dsp_fifo_rst(dsp_fifo_rst), .dsp_tg_rst(dsp_tg_rst), .cam_ovf(cam_ovf), .dsp_udf(dsp_udf)
  );

  int errors = 0, checks = 0;
  logic [PIX_W-1:0] rx [RXN];
  int  rx_n = 0;
  logic [PIX_W-1:0] ex [RXN];
  int  ex_n = 0;
  bit  disp_en = 1;
  int  disp_lines = LINES;
  bit  done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // output collector
  initial forever begin
    @(negedge dsp_clk);
    if (dsp_pix_vld) begin
      rx[rx_n % RXN] = dsp_pix;
      rx_n++;
    end
  end

  // display timing generator, slaved to dsp_tg_rst
  initial forever begin
    @(negedge dsp_clk);
    if (!dsp_tg_rst && disp_en) begin
      for (int l = 0; l < disp_lines && !dsp_tg_rst; l++) begin
        dsp_ls = 1; @(negedge dsp_clk); dsp_ls = 0;
        repeat (4) @(negedge dsp_clk);
        dsp_de = 1; repeat (LINE_PIX) @(negedge dsp_clk);
        dsp_de = 0; repeat (11) @(negedge dsp_clk);
      end
      while (!dsp_tg_rst) @(negedge dsp_clk);
    end
  end

  task automatic do_reset();
    cam_rst = 1; dsp_rst = 1;
    repeat (10) @(negedge cam_clk);
    cam_rst = 0; dsp_rst = 0;
    repeat (10) @(negedge cam_clk);
  endtask

  task automatic run_frame(input vec_t v);
    int k = 0;
    if (v.pre) begin
      for (int i = 0; i < 5; i++) begin
        cam_vld = 1; cam_pix = 24'hDEAD00 + 24'(i); @(negedge cam_clk);
      end
      cam_vld = 0;
    end
    repeat (5) @(negedge cam_clk);
    cam_fs = 1; @(negedge cam_clk); cam_fs = 0;
    repeat (20) @(negedge cam_clk);
    for (int l = 0; l < LINES; l++) begin
      cam_ls = 1; @(negedge cam_clk); cam_ls = 0;
      for (int p = 0; p < LINE_PIX; p++) begin
        cam_vld = 1;
        cam_pix = v.base + 24'(v.step) * 24'(k);
        ex[ex_n % RXN] = cam_pix; ex_n++;
        k++;
        @(negedge cam_clk);
      end
      cam_vld = 0;
      repeat (8) @(negedge cam_clk);
      if (l == 0) chk(dsp_tg_rst == 1'b1, "R4", "tg reset held after first line", dsp_tg_rst, 1);
      if (l == 1) begin
        chk(dsp_tg_rst == 1'b0, "R4", "tg reset released after second line start", dsp_tg_rst, 0);
        chk(cam_fifo_rst == 1'b0 && dsp_fifo_rst == 1'b0, "R3", "fifo clears low in frame",
            {cam_fifo_rst, dsp_fifo_rst}, 0);
      end
    end
    repeat (100) @(negedge cam_clk);
    cam_fe = 1; @(negedge cam_clk); cam_fe = 0;
    repeat (30) @(negedge cam_clk);
    chk(cam_fifo_rst == 1'b1 && dsp_fifo_rst == 1'b1, "R3", "fifo clears high after frame end",
        {cam_fifo_rst, dsp_fifo_rst}, 3);
    chk(dsp_tg_rst == 1'b1, "R4", "tg reset reasserted after frame end", dsp_tg_rst, 1);
  endtask

  initial begin
    repeat (200000) @(posedge dsp_clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int rx0, ex0, bad;
    repeat (3) @(negedge cam_clk);
    // R8 reset state
    chk(dsp_tg_rst && cam_fifo_rst && dsp_fifo_rst, "R8", "reset clears/tg high",
        {dsp_tg_rst, cam_fifo_rst, dsp_fifo_rst}, 7);
    chk(!dsp_pix_vld && !cam_ovf && !dsp_udf, "R8", "reset vld/flags low",
        {dsp_pix_vld, cam_ovf, dsp_udf}, 0);
    do_reset();

    // table of frames: R1 data order, R2 pre-frame junk dropped
    for (int t = 0; t < 4; t++) begin
      rx0 = rx_n; ex0 = ex_n;
      run_frame(VECS[t]);
      repeat (20) @(negedge dsp_clk);
      chk(rx_n - rx0 == LINES * LINE_PIX, VECS[t].pre ? "R2" : "R1", "pixels read out",
          rx_n - rx0, LINES * LINE_PIX);
      bad = 0;
      for (int i = 0; i < LINES * LINE_PIX; i++)
        if (rx[(rx0 + i) % RXN] !== ex[(ex0 + i) % RXN]) bad++;
      chk(bad == 0, "R1", "pixel values in order", bad, 0);
    end
    chk(!cam_ovf, "R6", "no overflow in normal frames", cam_ovf, 0);
    chk(!dsp_udf, "R7", "no underflow in normal frames", dsp_udf, 0);

    // R5/R6: no display line starts -> no reads, buffer fills
    disp_en = 0;
    rx0 = rx_n;
    run_frame(VECS[0]);
    chk(rx_n == rx0, "R5", "nothing read without display line start", rx_n - rx0, 0);
    chk(cam_ovf == 1'b1, "R6", "overflow flag set and kept after frame", cam_ovf, 1);
    do_reset();
    chk(!cam_ovf && !dsp_udf, "R8", "flags cleared by reset", {cam_ovf, dsp_udf}, 0);

    // R7: display runs more lines than the camera sends
    disp_en = 1; disp_lines = LINES + 2;
    rx0 = rx_n;
    run_frame(VECS[2]);
    repeat (20) @(negedge dsp_clk);
    chk(dsp_udf == 1'b1, "R7", "underflow flag set", dsp_udf, 1);
    chk(rx_n - rx0 == LINES * LINE_PIX, "R7", "empty reads give no valid", rx_n - rx0, LINES * LINE_PIX);
    chk(!cam_ovf, "R6", "no overflow during underflow test", cam_ovf, 0);

    do_reset();
    chk(!dsp_udf && dsp_tg_rst, "R8", "underflow cleared, tg held", {dsp_udf, dsp_tg_rst}, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule